// File: doc/BRIEF.md
# Interrupt enable and acceptance controller

This block holds the interrupt-enable state of a small 8-bit processor core and decides, once per instruction, whether the core should break off into an interrupt. It keeps two enable flags. The live flag gates maskable requests. The shadow flag keeps a copy of the live flag while a non-maskable interrupt is being serviced, so the handler's return can put the earlier state back.

The sequencer pulses `instr_done` in the last cycle of every instruction. In that same cycle it raises at most one decoded indication: enable (`op_ei`), disable (`op_di`) or return-from-non-maskable (`op_retn`). The block applies that instruction's effect on the flags and then makes the acceptance decision. It reports the decision one cycle later as a single-cycle `irq_ack` or `nmi_ack` pulse. The decoding of the instruction, vector fetch and stack handling stay in the sequencer.

There is no data stream here, so no valid/ready pairs and no back-pressure. Every pin is a plain control or status level or strobe.

Top module: `ien_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `ien_live`, `ien_shadow`, `irq_ack` and `nmi_ack` are all 0.
- R2: A boundary (`instr_done`=1) with `op_ei`=1 sets both `ien_live` and `ien_shadow` to 1 in the next cycle.
- R3: No maskable request is accepted at the boundary of the enabling instruction itself. The earliest maskable acceptance is at the next boundary.
- R4: Accepting a maskable request makes `irq_ack` 1 for the cycle after the boundary and clears both flags in that same cycle.
- R5: Enable, disable and maskable acceptance always leave `ien_live` equal to `ien_shadow`. Only a non-maskable acceptance can make them differ.
- R6: Accepting a non-maskable request clears `ien_live` and loads `ien_shadow` with the live value that the completing instruction left. Both changes appear in the cycle after the boundary, together with `nmi_ack`=1.
- R7: A boundary with `op_di`=1 clears both flags in the next cycle, and no maskable request is accepted at that boundary.
- R8: A boundary with `op_retn`=1 and no non-maskable acceptance copies `ien_shadow` into `ien_live` and leaves `ien_shadow` unchanged.
- R9: A rising edge on `nmi_line` is held until it is accepted at a later boundary, whatever the flags are. It wins over a maskable request at the same boundary. It yields exactly one acceptance per edge. A line that is already high when reset is released is not an edge.
- R10: Acceptance happens only in cycles with `instr_done`=1. `irq_ack` and `nmi_ack` are never 1 together, and each is 1 for one cycle only.
- R11: The maskable request is a level: it is accepted only if `irq_level` is 1 at a boundary where `ien_live` is 1.
- R12: `op_ei`, `op_di` and `op_retn` have no effect in cycles with `instr_done`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_done | input | 1 | Last cycle of an instruction (boundary) |
| op_ei | input | 1 | Completing instruction enables interrupts |
| op_di | input | 1 | Completing instruction disables interrupts |
| op_retn | input | 1 | Completing instruction returns from a non-maskable handler |
| irq_level | input | 1 | Maskable request, level sensitive |
| nmi_line | input | 1 | Non-maskable request, rising-edge sensitive |
| irq_ack | output | 1 | One-cycle pulse: maskable request accepted |
| nmi_ack | output | 1 | One-cycle pulse: non-maskable request accepted |
| ien_live | output | 1 | Live enable flag |
| ien_shadow | output | 1 | Shadow enable flag |

## Verification
The assertions assume that the sequencer never raises more than one of `op_ei`, `op_di` and `op_retn` in the same cycle. That rule is itself checked as an assertion. The bench issues each instruction through one task that drives exactly one indication at a time, so it stays inside this rule. The assertions also assume that `rst_n` is low at the first clock edge. The bench holds reset from time zero for several cycles to meet this.

// File: rtl/ien_pkg.sv
package ien_pkg;

  typedef enum logic [1:0] {
    OPC_NONE = 2'd0,
    OPC_EI   = 2'd1,
    OPC_DI   = 2'd2,
    OPC_RETN = 2'd3
  } op_cls_e;

  // Fold the decoded strobes into one class; strobes matter only at a boundary
  function automatic op_cls_e op_classify(input logic done, input logic ei,
                                          input logic di, input logic retn);
    op_cls_e c;
    c = OPC_NONE;
    if (done) begin
      if (ei)        c = OPC_EI;
      else if (di)   c = OPC_DI;
      else if (retn) c = OPC_RETN;
    end
    return c;
  endfunction

endpackage

// File: rtl/ien_nmi_catch.sv
module ien_nmi_catch #(
  parameter logic LINE_AT_RESET = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_line,
  input  logic take,
  output logic pend
);

  logic line_q;
  logic rise;

  assign rise = nmi_line & ~line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= LINE_AT_RESET;
      pend   <= 1'b0;
    end else begin
      line_q <= nmi_line;
      pend   <= (pend | rise) & ~take;
    end
  end

  // R9: an accepted request is consumed, so it cannot be taken twice
  p_nmi_consumed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !pend);

  // R9: a detected edge stays latched until it is accepted
  p_nmi_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !take) |=> pend);

endmodule

// File: rtl/ien_arbiter.sv
module ien_arbiter
  import ien_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    instr_done,
  input  op_cls_e op,
  input  logic    nmi_pend,
  input  logic    irq_level,
  input  logic    live,
  output logic    nmi_take,
  output logic    irq_take
);

  logic irq_blocked;

  // The enabling or disabling instruction's own boundary never admits a maskable request
  assign irq_blocked = (op == OPC_EI) || (op == OPC_DI);

  always_comb begin
    nmi_take = 1'b0;
    irq_take = 1'b0;
    if (instr_done) begin
      if (nmi_pend)
        nmi_take = 1'b1;
      else if (irq_level && live && !irq_blocked)
        irq_take = 1'b1;
    end
  end

  p_one_winner_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_take && irq_take));

  p_take_at_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_take || irq_take) |-> instr_done);

  p_no_irq_on_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OPC_EI) |-> !irq_take);

  p_irq_needs_live_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (live && irq_level));

  p_nmi_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && nmi_pend) |-> nmi_take);

endmodule

// File: rtl/ien_flags.sv
module ien_flags
  import ien_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  op_cls_e op,
  input  logic    nmi_take,
  input  logic    irq_take,
  output logic    live,
  output logic    shadow
);

  logic live_op, shadow_op;
  logic live_n, shadow_n;

  // First the completing instruction's own effect
  always_comb begin
    live_op   = live;
    shadow_op = shadow;
    unique case (op)
      OPC_EI:   begin live_op = 1'b1;   shadow_op = 1'b1; end
      OPC_DI:   begin live_op = 1'b0;   shadow_op = 1'b0; end
      OPC_RETN: begin live_op = shadow; end
      default:  ;
    endcase
  end

  // Then the acceptance on top of it
  always_comb begin
    live_n   = live_op;
    shadow_n = shadow_op;
    if (nmi_take) begin
      live_n   = 1'b0;
      shadow_n = live_op;
    end else if (irq_take) begin
      live_n   = 1'b0;
      shadow_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live   <= 1'b0;
      shadow <= 1'b0;
    end else begin
      live   <= live_n;
      shadow <= shadow_n;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!live && !shadow));

  p_enable_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OPC_EI && !nmi_take) |=> (live && shadow));

  p_irq_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (!live && !shadow));

  p_disable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OPC_DI) |=> (!live && !shadow));

  p_nmi_saves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_take && op == OPC_NONE) |=> (!live && shadow == $past(live)));

  p_retn_restores_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OPC_RETN && !nmi_take) |=> (live == $past(shadow) && $stable(shadow)));

  p_equal_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_take && op != OPC_RETN && live == shadow) |=> (live == shadow));

endmodule

// File: rtl/ien_ctrl.sv
module ien_ctrl
  import ien_pkg::*;
#(
  parameter logic NMI_LINE_AT_RESET = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic instr_done,
  input  logic op_ei,
  input  logic op_di,
  input  logic op_retn,
  input  logic irq_level,
  input  logic nmi_line,
  output logic irq_ack,
  output logic nmi_ack,
  output logic ien_live,
  output logic ien_shadow
);

  op_cls_e op;
  logic    nmi_pend;
  logic    nmi_take;
  logic    irq_take;

  assign op = op_classify(instr_done, op_ei, op_di, op_retn);

  ien_nmi_catch #(
    .LINE_AT_RESET(NMI_LINE_AT_RESET)
  ) u_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_line (nmi_line),
    .take     (nmi_take),
    .pend     (nmi_pend)
  );

  ien_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_done (instr_done),
    .op         (op),
    .nmi_pend   (nmi_pend),
    .irq_level  (irq_level),
    .live       (ien_live),
    .nmi_take   (nmi_take),
    .irq_take   (irq_take)
  );

  ien_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .nmi_take (nmi_take),
    .irq_take (irq_take),
    .live     (ien_live),
    .shadow   (ien_shadow)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_ack <= 1'b0;
      nmi_ack <= 1'b0;
    end else begin
      irq_ack <= irq_take;
      nmi_ack <= nmi_take;
    end
  end

  p_ops_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> $onehot0({op_ei, op_di, op_retn}));

  p_acks_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_ack && nmi_ack));

  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  p_nmi_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_ack |=> !nmi_ack);

  p_nmi_ack_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_ack |-> !ien_live);

  p_ack_after_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack || nmi_ack) |-> $past(instr_done));

endmodule

// File: tb/tb_ien_ctrl.sv
module tb_ien_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_done = 1'b0;
  logic op_ei = 1'b0, op_di = 1'b0, op_retn = 1'b0;
  logic irq_level = 1'b0;
  logic nmi_line = 1'b0;
  logic irq_ack, nmi_ack, ien_live, ien_shadow;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ien_ctrl dut (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done),
    .op_ei(op_ei), .op_di(op_di), .op_retn(op_retn),
    .irq_level(irq_level), .nmi_line(nmi_line),
    .irq_ack(irq_ack), .nmi_ack(nmi_ack),
    .ien_live(ien_live), .ien_shadow(ien_shadow)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Expected state of all four outputs
  task automatic chk_all(input string req, input logic ia, input logic na,
                         input logic lv, input logic sh);
    chk(req, "irq_ack", irq_ack, ia);
    chk(req, "nmi_ack", nmi_ack, na);
    chk(req, "ien_live", ien_live, lv);
    chk(req, "ien_shadow", ien_shadow, sh);
  endtask

  // One boundary cycle; on return the outputs show its registered result
  task automatic boundary(input logic ei, input logic di, input logic retn);
    @(negedge clk);
    instr_done = 1'b1; op_ei = ei; op_di = di; op_retn = retn;
    @(negedge clk);
    instr_done = 1'b0; op_ei = 1'b0; op_di = 1'b0; op_retn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  task automatic nmi_pulse();
    @(negedge clk);
    nmi_line = 1'b1;
    @(negedge clk);
    nmi_line = 1'b0;
  endtask

  task automatic t_reset();
    idle(1);
    chk_all("R1", 0, 0, 0, 0);
  endtask

  task automatic t_enable_delay();
    do_reset();
    irq_level = 1'b1;
    boundary(1, 0, 0);
    chk_all("R3", 0, 0, 1, 1);           // R2: both set, no accept on the enabling boundary
    boundary(0, 0, 0);
    chk_all("R4", 1, 0, 0, 0);           // R5: flags cleared together
    idle(1);
    chk("R10", "irq_ack pulse", irq_ack, 1'b0);
    boundary(0, 0, 0);
    chk("R4", "no retake while disabled", irq_ack, 1'b0);
    irq_level = 1'b0;
  endtask

  task automatic t_level();
    do_reset();
    boundary(1, 0, 0);
    boundary(0, 0, 0);
    chk_all("R11", 0, 0, 1, 1);          // level low: nothing accepted
    irq_level = 1'b1;
    idle(3);
    chk("R10", "no accept off boundary", irq_ack, 1'b0);
    chk("R10", "live kept off boundary", ien_live, 1'b1);
    boundary(0, 0, 0);
    chk("R11", "level accepted", irq_ack, 1'b1);
    irq_level = 1'b0;
  endtask

  task automatic t_disable();
    do_reset();
    boundary(1, 0, 0);
    irq_level = 1'b1;
    boundary(0, 0, 1'b0);
    irq_level = 1'b0;
    boundary(1, 0, 0);
    irq_level = 1'b1;
    boundary(0, 1, 0);
    chk_all("R7", 0, 0, 0, 0);
    boundary(0, 0, 0);
    chk("R7", "still disabled", irq_ack, 1'b0);
    irq_level = 1'b0;
  endtask

  task automatic t_ops_ignored();
    do_reset();
    @(negedge clk);
    op_ei = 1'b1;
    @(negedge clk);
    op_ei = 1'b0;
    chk("R12", "ei without boundary", ien_live, 1'b0);
    boundary(1, 0, 0);
    @(negedge clk);
    op_di = 1'b1;
    @(negedge clk);
    op_di = 1'b0;
    chk("R12", "di without boundary", ien_live, 1'b1);
  endtask

  task automatic t_nmi_save_restore();
    do_reset();
    boundary(1, 0, 0);
    nmi_pulse();
    idle(2);
    chk("R10", "nmi waits for boundary", nmi_ack, 1'b0);
    irq_level = 1'b1;
    boundary(0, 0, 0);
    chk_all("R6", 0, 1, 0, 1);           // R9: nmi wins over level
    idle(1);
    chk("R10", "nmi_ack pulse", nmi_ack, 1'b0);
    boundary(0, 0, 0);
    chk_all("R9", 0, 0, 0, 1);           // one accept per edge
    boundary(0, 0, 1);
    chk_all("R8", 0, 0, 1, 1);
    boundary(0, 0, 0);
    chk("R5", "irq after restore", irq_ack, 1'b1);
    irq_level = 1'b0;
  endtask

  task automatic t_nmi_disabled();
    do_reset();
    nmi_pulse();
    boundary(0, 0, 0);
    chk_all("R9", 0, 1, 0, 0);
    boundary(0, 0, 1);
    chk_all("R8", 0, 0, 0, 0);
  endtask

  task automatic t_nmi_on_enable();
    do_reset();
    nmi_pulse();
    irq_level = 1'b1;
    boundary(1, 0, 0);
    chk_all("R6", 0, 1, 0, 1);
    irq_level = 1'b0;
  endtask

  task automatic t_nmi_held();
    do_reset();
    @(negedge clk);
    nmi_line = 1'b1;
    boundary(0, 0, 0);
    chk("R9", "held line accepted once", nmi_ack, 1'b1);
    boundary(0, 0, 0);
    chk("R9", "held line no retrigger", nmi_ack, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    boundary(0, 0, 0);
    chk("R9", "high across reset no edge", nmi_ack, 1'b0);
    nmi_line = 1'b0;
    idle(1);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    t_reset();
    t_enable_delay();
    t_level();
    t_disable();
    t_ops_ignored();
    t_nmi_save_restore();
    t_nmi_disabled();
    t_nmi_on_enable();
    t_nmi_held();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule